// File: doc/BRIEF.md
# CCM Authenticated-Cipher Phase Sequencer

This block runs counter-with-CBC-MAC (CCM) authenticated encryption around an external 128-bit block cipher. Software drives it through a small set of fields: an enable bit, a 4-bit algorithm code, a 2-bit phase and a direction bit. It pushes 32-bit words into an input queue and pops 32-bit words from an output queue. Every four input words form one 128-bit block, and the first word written is the most significant. Each block is handled according to the current phase. The block keeps the CBC-MAC accumulator and the counter block itself. The cipher is reached through a single-request, single-response port.

Software steps through the phases in order. In the prepare phase, the initial block seeds the MAC and the counter, and the block then clears its own enable bit. In the associated-data phase, each block is absorbed into the MAC and nothing is output. The associated-data phase may be skipped. In the payload phase, each block is XORed with an encrypted counter to give one output block, and the plaintext is folded into the MAC. In the tag phase, the first counter block is encrypted and XORed with the MAC, and the result is returned as the tag.

Top module: `ccm_phase_seq`

## Requirements
- R1: After reset the enable bit and phase read back as 0 and 2'b00. The input-empty and input-not-full flags are 1, the output-not-empty and output-full flags are 0, and busy is 0.
- R2: A 4-word input block is taken only while the enable bit is 1 and the algorithm code is 4'b1001. Otherwise words stay queued, no cipher request is made, and busy stays high while the input queue is not empty.
- R3: Prepare phase (2'b00): MAC := E(B0). When that cipher response arrives, the enable bit is cleared. A software write of the enable bit in the same cycle loses to this clear.
- R4: No word enters the output queue while the phase is 2'b00 or 2'b01.
- R5: Associated-data phase (2'b01): each block A updates MAC := E(MAC xor A). Busy is high from the first queued word until the last block has been absorbed.
- R6: Payload phase (2'b10): before each block the counter's low 32 bits are incremented modulo 2^32. The output block is data xor E(counter), pushed as 4 words with the most significant word first.
- R7: The direction bit is 0 for encrypt and 1 for decrypt. The MAC is then updated as MAC := E(MAC xor P), where P is the input block when encrypting and the output block when decrypting.
- R8: Tag phase (2'b11): the input block A0 produces the output E(A0) xor MAC as 4 words.
- R9: A write to the phase field while busy is 1 leaves the phase unchanged. The other fields still take the written values.
- R10: Both queues hold 8 words. The input-not-full flag is 0 at 8 queued words, and the output-full flag is 1 at 8 words. A block is taken in phase 2'b10 or 2'b11 only when the output queue has room for 4 words.
- R11: The counter seed is B0 with bits [127:123] cleared and its low L bytes cleared, where L = B0[122:120] + 1.
- R12: Each cipher operation is a one-cycle request pulse with a 128-bit operand, issued only while busy. A payload block takes two operations and every other block takes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the control fields |
| cfg_en | input | 1 | Enable bit value to write |
| cfg_algo | input | 4 | Algorithm code to write (4'b1001 selects CCM) |
| cfg_phase | input | 2 | Phase to write |
| cfg_dir | input | 1 | Direction to write: 0 encrypt, 1 decrypt |
| en_o | output | 1 | Current enable bit |
| phase_o | output | 2 | Current phase |
| din_valid | input | 1 | Push one word into the input queue |
| din_data | input | WORD_W | Input word |
| dout_rd | input | 1 | Pop one word from the output queue |
| dout_data | output | WORD_W | Head word of the output queue |
| in_empty | output | 1 | Input queue empty |
| in_not_full | output | 1 | Input queue can take a word |
| out_not_empty | output | 1 | Output queue holds a word |
| out_full | output | 1 | Output queue full |
| busy | output | 1 | Engine active or input words pending |
| ciph_req | output | 1 | Cipher request pulse |
| ciph_blk | output | 128 | Cipher operand |
| ciph_vld | input | 1 | Cipher response strobe |
| ciph_res | input | 128 | Cipher result |

## Verification
Two events can land in the same clock edge: the cipher response that ends the prepare phase (and clears the enable bit) and a software write to the control fields. The bench's cipher responder raises its response strobe and, in the same cycle, drives a control write that sets the enable bit and asks for phase 2'b01. Afterward the enable bit must read 0 and the phase must still read 2'b00, because the hardware clear wins and the phase write arrived while busy.

// File: rtl/ccm_seq_pkg.sv
package ccm_seq_pkg;
   localparam int BLK_W = 128;
   localparam logic [3:0] ALG_CCM = 4'b1001;

   typedef enum logic [1:0] {
      PH_PREP = 2'b00,
      PH_AAD  = 2'b01,
      PH_PAY  = 2'b10,
      PH_TAG  = 2'b11
   } phase_e;

   typedef enum logic {ST_IDLE, ST_WAIT} eng_st_e;

   typedef enum logic [1:0] {OP_MAC, OP_KS, OP_TAG} op_e;

   // Counter seed: flag bits above the length code cleared, low L bytes zeroed.
   function automatic logic [BLK_W-1:0] ctr_seed(input logic [BLK_W-1:0] b0);
      logic [BLK_W-1:0] c;
      int nbytes;
      c = b0;
      c[127:123] = 5'd0;
      nbytes = int'({29'd0, b0[122:120]}) + 1;
      for (int i = 0; i < 8; i++) begin
         if (i < nbytes) c[8*i +: 8] = 8'd0;
      end
      return c;
   endfunction

   function automatic logic [BLK_W-1:0] ctr_step(input logic [BLK_W-1:0] c);
      return {c[BLK_W-1:32], c[31:0] + 32'd1};
   endfunction
endpackage

// File: rtl/ccm_word_fifo.sv
module ccm_word_fifo #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 8,
   parameter int PUSH_N = 1,
   parameter int POP_N  = 4,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [PUSH_N*WORD_W-1:0] push_data,
   input  logic                     pop,
   output logic [POP_N*WORD_W-1:0]  pop_data,
   output logic [CW-1:0]            level
);
   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2*PUSH_N || DEPTH < 2*POP_N) begin : g_bad_depth
      $error("ccm_word_fifo: DEPTH must be a power of two holding two transfers");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wp, rp;
   logic [CW-1:0]     lvl;
   logic              do_push, do_pop;

   assign do_push = push && (lvl <= CW'(DEPTH - PUSH_N));
   assign do_pop  = pop  && (lvl >= CW'(POP_N));
   assign level   = lvl;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         lvl <= '0;
      end else begin
         if (do_push) wp <= wp + AW'(PUSH_N);
         if (do_pop)  rp <= rp + AW'(POP_N);
         lvl <= lvl + (do_push ? CW'(PUSH_N) : '0) - (do_pop ? CW'(POP_N) : '0);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         for (int i = 0; i < PUSH_N; i++) begin
            mem[wp + AW'(i)] <= push_data[(PUSH_N-i)*WORD_W-1 -: WORD_W];
         end
      end
   end

   for (genvar g = 0; g < POP_N; g++) begin : g_pop
      assign pop_data[(POP_N-g)*WORD_W-1 -: WORD_W] = mem[rp + AW'(g)];
   end
endmodule

// File: rtl/ccm_cfg_regs.sv
module ccm_cfg_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       wr_en,
   input  logic [3:0] wr_algo,
   input  logic [1:0] wr_phase,
   input  logic       wr_dir,
   input  logic       busy,
   input  logic       hw_clr,
   output logic       en,
   output logic [3:0] algo,
   output logic [1:0] phase,
   output logic       dir
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         algo  <= 4'd0;
         phase <= 2'b00;
         dir   <= 1'b0;
      end else begin
         if (wr) begin
            en   <= wr_en;
            algo <= wr_algo;
            dir  <= wr_dir;
            if (!busy) phase <= wr_phase;
         end
         // hardware clear after the seed block overrides a same-cycle write
         if (hw_clr) en <= 1'b0;
      end
   end
endmodule

// File: rtl/ccm_engine.sv
module ccm_engine
   import ccm_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             algo_ok,
   input  phase_e           phase,
   input  logic             dir,
   input  logic             in_avail,
   input  logic [BLK_W-1:0] in_blk,
   output logic             in_pop,
   input  logic             out_room,
   output logic             out_push,
   output logic [BLK_W-1:0] out_blk,
   output logic             ciph_req,
   output logic [BLK_W-1:0] ciph_blk,
   input  logic             ciph_vld,
   input  logic [BLK_W-1:0] ciph_res,
   output logic             active,
   output logic             en_clr,
   output logic             start
);
   eng_st_e          st_q;
   op_e              op_q;
   phase_e           ph_q;
   logic             dir_q;
   logic [BLK_W-1:0] mac_q, ctr_q, blk_q, cblk_q;
   logic             req_q;
   logic             done;
   logic [BLK_W-1:0] ks_out, plain;

   assign start    = (st_q == ST_IDLE) && en && algo_ok && in_avail &&
                     (phase[1] ? out_room : 1'b1);
   assign in_pop   = start;
   assign active   = (st_q != ST_IDLE);
   assign done     = (st_q == ST_WAIT) && ciph_vld;
   assign ks_out   = blk_q ^ ciph_res;
   assign plain    = dir_q ? ks_out : blk_q;
   assign out_blk  = (op_q == OP_KS) ? ks_out : (ciph_res ^ mac_q);
   assign out_push = done && (op_q == OP_KS || op_q == OP_TAG);
   assign en_clr   = done && (op_q == OP_MAC) && (ph_q == PH_PREP);
   assign ciph_req = req_q;
   assign ciph_blk = cblk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= OP_MAC;
         ph_q   <= PH_PREP;
         dir_q  <= 1'b0;
         mac_q  <= '0;
         ctr_q  <= '0;
         blk_q  <= '0;
         cblk_q <= '0;
         req_q  <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (start) begin
            blk_q <= in_blk;
            ph_q  <= phase;
            dir_q <= dir;
            st_q  <= ST_WAIT;
            req_q <= 1'b1;
            unique case (phase)
               PH_PREP: begin
                  op_q   <= OP_MAC;
                  cblk_q <= in_blk;
                  ctr_q  <= ctr_seed(in_blk);
               end
               PH_AAD: begin
                  op_q   <= OP_MAC;
                  cblk_q <= mac_q ^ in_blk;
               end
               PH_PAY: begin
                  op_q   <= OP_KS;
                  ctr_q  <= ctr_step(ctr_q);
                  cblk_q <= ctr_step(ctr_q);
               end
               PH_TAG: begin
                  op_q   <= OP_TAG;
                  cblk_q <= in_blk;
               end
            endcase
         end else if (done) begin
            unique case (op_q)
               OP_MAC: begin
                  mac_q <= ciph_res;
                  st_q  <= ST_IDLE;
               end
               OP_KS: begin
                  op_q   <= OP_MAC;
                  cblk_q <= mac_q ^ plain;
                  req_q  <= 1'b1;
               end
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/ccm_phase_seq.sv
module ccm_phase_seq
   import ccm_seq_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int IN_DEPTH  = 8,
   parameter int OUT_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_en,
   input  logic [3:0]        cfg_algo,
   input  logic [1:0]        cfg_phase,
   input  logic              cfg_dir,
   output logic              en_o,
   output logic [1:0]        phase_o,
   input  logic              din_valid,
   input  logic [WORD_W-1:0] din_data,
   input  logic              dout_rd,
   output logic [WORD_W-1:0] dout_data,
   output logic              in_empty,
   output logic              in_not_full,
   output logic              out_not_empty,
   output logic              out_full,
   output logic              busy,
   output logic              ciph_req,
   output logic [127:0]      ciph_blk,
   input  logic              ciph_vld,
   input  logic [127:0]      ciph_res
);
   localparam int WORDS = BLK_W / WORD_W;
   localparam int ICW   = $clog2(IN_DEPTH + 1);
   localparam int OCW   = $clog2(OUT_DEPTH + 1);

   if (BLK_W % WORD_W != 0) begin : g_bad_word
      $error("ccm_phase_seq: WORD_W must divide the block width");
   end

   logic [3:0]       algo;
   logic             dir;
   logic             algo_ok;
   logic [ICW-1:0]   in_lvl;
   logic [OCW-1:0]   out_lvl;
   logic [BLK_W-1:0] in_blk, out_blk;
   logic             in_pop, in_avail, out_room;
   logic             eng_active, eng_en_clr, eng_start, eng_out_push;

   assign algo_ok       = (algo == ALG_CCM);
   assign in_empty      = (in_lvl == '0);
   assign in_not_full   = (in_lvl < ICW'(IN_DEPTH));
   assign in_avail      = (in_lvl >= ICW'(WORDS));
   assign out_not_empty = (out_lvl != '0);
   assign out_full      = (out_lvl == OCW'(OUT_DEPTH));
   assign out_room      = (out_lvl <= OCW'(OUT_DEPTH - WORDS));
   assign busy          = eng_active || !in_empty;

   ccm_cfg_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (cfg_wr),
      .wr_en    (cfg_en),
      .wr_algo  (cfg_algo),
      .wr_phase (cfg_phase),
      .wr_dir   (cfg_dir),
      .busy     (busy),
      .hw_clr   (eng_en_clr),
      .en       (en_o),
      .algo     (algo),
      .phase    (phase_o),
      .dir      (dir)
   );

   ccm_word_fifo #(.WORD_W(WORD_W), .DEPTH(IN_DEPTH), .PUSH_N(1), .POP_N(WORDS)) u_in_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (din_valid),
      .push_data (din_data),
      .pop       (in_pop),
      .pop_data  (in_blk),
      .level     (in_lvl)
   );

   ccm_word_fifo #(.WORD_W(WORD_W), .DEPTH(OUT_DEPTH), .PUSH_N(WORDS), .POP_N(1)) u_out_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (eng_out_push),
      .push_data (out_blk),
      .pop       (dout_rd),
      .pop_data  (dout_data),
      .level     (out_lvl)
   );

   ccm_engine u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en_o),
      .algo_ok  (algo_ok),
      .phase    (phase_e'(phase_o)),
      .dir      (dir),
      .in_avail (in_avail),
      .in_blk   (in_blk),
      .in_pop   (in_pop),
      .out_room (out_room),
      .out_push (eng_out_push),
      .out_blk  (out_blk),
      .ciph_req (ciph_req),
      .ciph_blk (ciph_blk),
      .ciph_vld (ciph_vld),
      .ciph_res (ciph_res),
      .active   (eng_active),
      .en_clr   (eng_en_clr),
      .start    (eng_start)
   );
endmodule

// File: rtl/ccm_phase_seq_chk.sv
module ccm_phase_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_o,
   input logic [1:0] phase_o,
   input logic       busy,
   input logic       cfg_wr,
   input logic       in_empty,
   input logic       out_full,
   input logic       ciph_req,
   input logic       en_clr,
   input logic       out_push
);
   // R3
   en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> !en_o);

   // R9
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_wr) |=> $stable(phase_o));

   // R4
   early_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_push |-> phase_o[1]);

   // R10
   out_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_push |-> !out_full);

   // R12
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ciph_req |=> !ciph_req);

   // R12
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ciph_req |-> busy);

   // R5
   pending_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_empty |-> busy);
endmodule

bind ccm_phase_seq ccm_phase_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en_o     (en_o),
   .phase_o  (phase_o),
   .busy     (busy),
   .cfg_wr   (cfg_wr),
   .in_empty (in_empty),
   .out_full (out_full),
   .ciph_req (ciph_req),
   .en_clr   (eng_en_clr),
   .out_push (eng_out_push)
);

// File: tb/ccm_phase_seq_tb.sv
module ccm_phase_seq_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_wr = 1'b0, cfg_en = 1'b0, cfg_dir = 1'b0;
   logic [3:0]   cfg_algo = 4'd0;
   logic [1:0]   cfg_phase = 2'b00;
   logic         en_o;
   logic [1:0]   phase_o;
   logic         din_valid = 1'b0;
   logic [31:0]  din_data = 32'd0;
   logic         dout_rd = 1'b0;
   logic [31:0]  dout_data;
   logic         in_empty, in_not_full, out_not_empty, out_full, busy;
   logic         ciph_req;
   logic [127:0] ciph_blk;
   logic         ciph_vld = 1'b0;
   logic [127:0] ciph_res = '0;

   int errs = 0, checks = 0, req_cnt = 0, pend = 0;
   bit collide = 1'b0, resp_wrote = 1'b0, done = 1'b0, mon_on = 1'b0;
   logic [127:0] held;
   logic [31:0]  expq[$];

   always #2.5 clk = ~clk;

   ccm_phase_seq u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_algo(cfg_algo),
      .cfg_phase(cfg_phase), .cfg_dir(cfg_dir), .en_o(en_o), .phase_o(phase_o),
      .din_valid(din_valid), .din_data(din_data), .dout_rd(dout_rd), .dout_data(dout_data),
      .in_empty(in_empty), .in_not_full(in_not_full), .out_not_empty(out_not_empty),
      .out_full(out_full), .busy(busy), .ciph_req(ciph_req), .ciph_blk(ciph_blk),
      .ciph_vld(ciph_vld), .ciph_res(ciph_res)
   );

   function automatic logic [127:0] enc(input logic [127:0] x);
      return {x[90:0], x[127:91]} ^ 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
   endfunction

   function automatic logic [127:0] seed_of(input logic [127:0] b0);
      logic [127:0] c = b0;
      c[127:123] = '0;
      for (int i = 0; i <= int'(b0[122:120]); i++) c[8*i +: 8] = 8'h00;
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   // cipher responder: fixed latency of 3, may inject a colliding control write
   initial begin
      forever begin
         @(negedge clk);
         ciph_vld = 1'b0;
         if (resp_wrote) begin cfg_wr = 1'b0; resp_wrote = 1'b0; end
         if (!rst_n) pend = 0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               ciph_vld = 1'b1;
               ciph_res = enc(held);
               if (collide) begin
                  cfg_wr = 1'b1; cfg_en = 1'b1; cfg_algo = 4'b1001;
                  cfg_phase = 2'b01; cfg_dir = 1'b0;
                  collide = 1'b0; resp_wrote = 1'b1;
               end
            end
         end
         if (rst_n && ciph_req) begin
            held = ciph_blk; req_cnt++; pend = 3;
         end
      end
   end

   // per-clock comparison against the phase model: R4
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && mon_on) begin
            if (phase_o[1] == 1'b0) chk(!out_not_empty, "R4 early-phase output", out_not_empty, 0);
         end
      end
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         summary();
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; din_valid = 1'b0; dout_rd = 1'b0; cfg_wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req_cnt = 0;
   endtask

   task automatic cfg(input bit en, input logic [3:0] algo, input logic [1:0] ph, input bit dir);
      @(negedge clk);
      cfg_en = en; cfg_algo = algo; cfg_phase = ph; cfg_dir = dir; cfg_wr = 1'b1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic put_word(input logic [31:0] w);
      @(negedge clk);
      din_valid = 1'b1; din_data = w;
      @(negedge clk);
      din_valid = 1'b0;
   endtask

   task automatic put_blk(input logic [127:0] b);
      for (int k = 0; k < 4; k++) put_word(b[127-32*k -: 32]);
   endtask

   task automatic exp_blk(input logic [127:0] b);
      for (int k = 0; k < 4; k++) expq.push_back(b[127-32*k -: 32]);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
   endtask

   task automatic read_words(input int n, input string req);
      for (int k = 0; k < n; k++) begin
         logic [31:0] e;
         while (!out_not_empty) @(negedge clk);
         e = expq.pop_front();
         chk(dout_data == e, req, dout_data, e);
         dout_rd = 1'b1;
         @(negedge clk);
         dout_rd = 1'b0;
      end
   endtask

   initial begin
      logic [127:0] b0, a0b, a1b, p0, p1, p2, ctr0, ctr, mac, ks, ob;
      b0  = 128'h5a112233_44556677_8899aabb_ccddeeff;
      a0b = 128'h01020304_05060708_090a0b0c_0d0e0f10;
      a1b = 128'hdeadbeef_00c0ffee_12345678_9abcdef0;
      p0  = 128'h11111111_22222222_33333333_44444444;
      p1  = 128'hcafef00d_8badf00d_0badc0de_feedface;
      p2  = 128'h76543210_fedcba98_01234567_89abcdef;

      // R1 reset state
      do_reset();
      @(negedge clk);
      chk(en_o == 1'b0 && phase_o == 2'b00, "R1 control reset", {en_o, phase_o}, 0);
      chk(in_empty && in_not_full && !out_not_empty && !out_full && !busy, "R1 flag reset",
          {in_empty, in_not_full, out_not_empty, out_full, busy}, 5'b11000);

      // R2 wrong algorithm code keeps words queued
      cfg(1'b1, 4'b0001, 2'b00, 1'b0);
      put_blk(b0);
      repeat (12) @(negedge clk);
      chk(req_cnt == 0 && !in_empty, "R2 no start without CCM code", req_cnt, 0);
      chk(busy == 1'b1, "R2 busy with queued words", busy, 1);

      // R10 input queue fill with enable low
      do_reset();
      cfg(1'b0, 4'b1001, 2'b00, 1'b0);
      for (int k = 0; k < 7; k++) put_word(32'h100 + k);
      chk(in_not_full == 1'b1, "R10 seven words not full", in_not_full, 1);
      put_word(32'h200);
      chk(in_not_full == 1'b0 && !in_empty, "R10 eight words full", in_not_full, 0);

      // main flow
      do_reset();
      mon_on = 1'b1;
      cfg(1'b1, 4'b1001, 2'b00, 1'b0);
      collide = 1'b1;
      put_blk(b0);
      wait_idle();
      mac = enc(b0);
      ctr0 = seed_of(b0);
      chk(en_o == 1'b0, "R3 enable cleared, beats same-cycle write", en_o, 0);
      chk(phase_o == 2'b00, "R9 phase write during busy ignored", phase_o, 0);
      chk(req_cnt == 1, "R12 one request for seed block", req_cnt, 1);

      cfg(1'b1, 4'b1001, 2'b01, 1'b0);
      put_word(a0b[127:96]);
      chk(busy == 1'b1, "R5 busy from first queued word", busy, 1);
      cfg(1'b1, 4'b1001, 2'b10, 1'b0);
      put_word(a0b[95:64]); put_word(a0b[63:32]); put_word(a0b[31:0]);
      put_blk(a1b);
      wait_idle();
      mac = enc(mac ^ a0b);
      mac = enc(mac ^ a1b);
      chk(phase_o == 2'b01, "R9 phase held during AAD", phase_o, 1);
      chk(!out_not_empty, "R4 no output after AAD", out_not_empty, 0);
      chk(req_cnt == 3, "R12 one request per AAD block", req_cnt, 3);

      // payload, encrypt, two blocks without reading
      cfg(1'b1, 4'b1001, 2'b10, 1'b0);
      ctr = ctr0;
      put_blk(p0); put_blk(p1);
      wait_idle();
      ctr = {ctr[127:32], ctr[31:0] + 32'd1};
      ks = enc(ctr); ob = p0 ^ ks; exp_blk(ob); mac = enc(mac ^ p0);
      ctr = {ctr[127:32], ctr[31:0] + 32'd1};
      ks = enc(ctr); ob = p1 ^ ks; exp_blk(ob); mac = enc(mac ^ p1);
      chk(out_full == 1'b1, "R10 output full at eight words", out_full, 1);
      read_words(8, "R6 R11 encrypt keystream output");

      // payload, decrypt
      cfg(1'b1, 4'b1001, 2'b10, 1'b1);
      put_blk(p2);
      ctr = {ctr[127:32], ctr[31:0] + 32'd1};
      ks = enc(ctr); ob = p2 ^ ks; exp_blk(ob); mac = enc(mac ^ ob);
      read_words(4, "R6 decrypt output");
      wait_idle();
      chk(req_cnt == 9, "R12 two requests per payload block", req_cnt, 9);

      // tag
      cfg(1'b1, 4'b1001, 2'b11, 1'b0);
      put_blk(ctr0);
      exp_blk(enc(ctr0) ^ mac);
      read_words(4, "R8 R7 R5 tag value");
      wait_idle();
      chk(!out_not_empty && in_empty, "R8 queues drained after tag", out_not_empty, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule